// File: doc/BRIEF.md
# Balanced-Ternary Sixteen-Trit ALU

This block carries out one arithmetic or logic operation on two balanced-ternary operands. Each operand is a vector of trits, and each trit holds -1, 0 or +1. A core's decode stage presents the instruction's major opcode, its three-bit function select and the two operands, together with a valid strobe. The ALU works only on its own custom major opcode and ignores everything else. The result is registered and returned one clock later with a one-cycle result-valid pulse.

Arithmetic works trit by trit. Each sum is clamped to the trit range, so there is no carry chain. Whenever a position saturates, a sticky overflow flag is raised. It stays set until software pulses a clear input. The one unused function code gives a zero result and raises an illegal-operation output for that result.

Two small state machines do the control work. The result machine has the states RS_IDLE and RS_DONE. It moves from RS_IDLE to RS_DONE when an operation is accepted. It stays in RS_DONE while operations keep arriving back to back, and it returns to RS_IDLE on the first cycle with no accepted operation. The flag machine has the states FL_CLEAR and FL_SET. It moves from FL_CLEAR to FL_SET on an overflow event. It moves from FL_SET back to FL_CLEAR on a clear request, but only when no overflow event arrives in the same cycle. Otherwise it holds its state.

Top module: `tern_alu`

## Requirements
- R1: Each trit uses two bits: 2'b00 means 0, 2'b01 means +1 and 2'b11 means -1. An input trit of 2'b10 is read as 0. A result trit is never 2'b10. Trit i sits at bits [2i+1:2i].
- R2: An operation is accepted on a rising edge where `valid_i` is high and `opcode_i` equals 7'h0B. After that edge, `res_o` carries the result and `res_valid_o` is high for that one cycle. In a cycle with no accepted operation, `res_valid_o` is low after the edge and `res_o` keeps its value.
- R3: When `funct3_i` is 0 (add), each result trit is a+b clamped to [-1,+1]. So (-1)+(-1) gives -1, (+1)+(+1) gives +1, (-1)+(+1) gives 0, and adding 0 passes the other trit through.
- R4: When `funct3_i` is 1 (subtract), each result trit is a+(-b). It uses the same clamping and the same overflow rule as add.
- R5: When `funct3_i` is 2 (multiply), each result trit is a*b: +1 for equal non-zero trits, -1 for opposite non-zero trits, and 0 if either trit is 0.
- R6: When `funct3_i` is 3, each result trit is min(a,b). When `funct3_i` is 4, each result trit is max(a,b).
- R7: When `funct3_i` is 5, each result trit is max(min(a,-b), min(-a,b)).
- R8: When `funct3_i` is 6, each result trit is -a, and `opb_i` has no effect on the result.
- R9: When `funct3_i` is 7, the result is all zero and `illegal_o` is high for that result. For function codes 0 to 6, `illegal_o` is low after the edge.
- R10: `ovf_o` is set after the edge that accepts an add or subtract in which any trit position saturates. Once set, it stays set. Only add and subtract can set it.
- R11: When `ovf_clr_i` is high at an edge, `ovf_o` reads 0 after that edge. The exception is an overflowing operation accepted at the same edge: then `ovf_o` stays 1.
- R12: While `rst_n` is low, `res_o` is zero and `res_valid_o`, `ovf_o` and `illegal_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction presented this cycle |
| opcode_i | input | 7 | Major opcode of the instruction |
| funct3_i | input | 3 | Function select |
| opa_i | input | 2*NTRIT | First operand, two bits per trit |
| opb_i | input | 2*NTRIT | Second operand, two bits per trit |
| ovf_clr_i | input | 1 | Clear request for the sticky overflow flag |
| res_o | output | 2*NTRIT | Registered result |
| res_valid_o | output | 1 | One-cycle pulse with each new result |
| ovf_o | output | 1 | Sticky overflow flag |
| illegal_o | output | 1 | The current result came from the unused function code |

## Verification
The bench builds the ALU with NTRIT = 2. With that setting, every 4-bit operand value can be swept: all sixteen two-trit combinations for each operand, including the invalid 2'b10 code in either position. The sweep runs all 16×16 operand pairs under all eight function codes. For each case it checks the result, the illegal output and the overflow flag, against a model computed from integer trit values. Because the lanes are identical and carry-free, this small width reaches every per-position case that the 16-trit default can produce. Directed sequences then cover the cases the sweep does not: a strobe with the wrong opcode or with valid low, stickiness of the flag, and a clear that collides with an overflowing operation.

// File: rtl/tern_pkg.sv
package tern_pkg;

    localparam logic [6:0] TERN_MAJOR = 7'h0B;

    localparam logic [1:0] TC_ZERO = 2'b00;
    localparam logic [1:0] TC_POS  = 2'b01;
    localparam logic [1:0] TC_NEG  = 2'b11;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_XOR = 3'd5,
        OP_NOT = 3'd6,
        OP_BAD = 3'd7
    } tern_op_e;

    // Trit value as a small signed integer in [-1,+1] (sums may reach +/-2)
    typedef logic signed [2:0] tval_t;

    function automatic tval_t tdec(input logic [1:0] code);
        tval_t v;
        unique case (code)
            TC_POS:  v = 3'sd1;
            TC_NEG:  v = -3'sd1;
            default: v = 3'sd0;   // 00 and the invalid 10
        endcase
        return v;
    endfunction

    function automatic logic [1:0] tenc(input tval_t v);
        logic [1:0] c;
        if (v > 3'sd0)      c = TC_POS;
        else if (v < 3'sd0) c = TC_NEG;
        else                c = TC_ZERO;
        return c;
    endfunction

    function automatic tval_t tmin(input tval_t x, input tval_t y);
        return (x < y) ? x : y;
    endfunction

    function automatic tval_t tmax(input tval_t x, input tval_t y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/tern_decode.sv
module tern_decode
    import tern_pkg::*;
(
    input  logic       valid_i,
    input  logic [6:0] opcode_i,
    input  logic [2:0] funct3_i,
    output logic       accept_o,
    output tern_op_e   op_o,
    output logic       bad_o,
    output logic       arith_o
);

    always_comb begin
        accept_o = valid_i && (opcode_i == TERN_MAJOR);
        op_o     = tern_op_e'(funct3_i);
        bad_o    = (op_o == OP_BAD);
        arith_o  = (op_o == OP_ADD) || (op_o == OP_SUB);
    end

endmodule

// File: rtl/tern_lane.sv
module tern_lane
    import tern_pkg::*;
(
    input  tern_op_e   op_i,
    input  logic [1:0] a_i,
    input  logic [1:0] b_i,
    output logic [1:0] r_o,
    output logic       sat_o
);

    tval_t av, bv, addend, sum, rv;

    always_comb begin
        av     = tdec(a_i);
        bv     = tdec(b_i);
        addend = (op_i == OP_SUB) ? -bv : bv;
        sum    = av + addend;
        sat_o  = 1'b0;
        rv     = 3'sd0;
        unique case (op_i)
            OP_ADD, OP_SUB: begin
                if (sum > 3'sd1) begin
                    rv    = 3'sd1;
                    sat_o = 1'b1;
                end else if (sum < -3'sd1) begin
                    rv    = -3'sd1;
                    sat_o = 1'b1;
                end else begin
                    rv = sum;
                end
            end
            OP_MUL:  rv = av * bv;
            OP_AND:  rv = tmin(av, bv);
            OP_OR:   rv = tmax(av, bv);
            OP_XOR:  rv = tmax(tmin(av, -bv), tmin(-av, bv));
            OP_NOT:  rv = -av;
            OP_BAD:  rv = 3'sd0;
        endcase
        r_o = tenc(rv);
    end

endmodule

// File: rtl/tern_flag.sv
module tern_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef enum logic {FL_CLEAR = 1'b0, FL_SET = 1'b1} flag_state_e;

    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: if (set_i)           state_d = FL_SET;
            FL_SET:   if (clr_i && !set_i) state_d = FL_CLEAR;
        endcase
    end

    always_comb flag_o = (state_q == FL_SET);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/tern_alu.sv
module tern_alu
    import tern_pkg::*;
#(
    parameter int NTRIT = 16,
    localparam int W = 2 * NTRIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [6:0]   opcode_i,
    input  logic [2:0]   funct3_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         ovf_clr_i,
    output logic [W-1:0] res_o,
    output logic         res_valid_o,
    output logic         ovf_o,
    output logic         illegal_o
);

    typedef enum logic {RS_IDLE = 1'b0, RS_DONE = 1'b1} res_state_e;

    logic             accept, is_bad, is_arith, ovf_evt;
    tern_op_e         op;
    logic [W-1:0]     lane_res;
    logic [NTRIT-1:0] lane_sat;
    res_state_e       state_q, state_d;
    logic [W-1:0]     res_q;
    logic             bad_q;

    tern_decode u_dec (
        .valid_i  (valid_i),
        .opcode_i (opcode_i),
        .funct3_i (funct3_i),
        .accept_o (accept),
        .op_o     (op),
        .bad_o    (is_bad),
        .arith_o  (is_arith)
    );

    for (genvar g = 0; g < NTRIT; g++) begin : g_lane
        tern_lane u_lane (
            .op_i  (op),
            .a_i   (opa_i[2*g +: 2]),
            .b_i   (opb_i[2*g +: 2]),
            .r_o   (lane_res[2*g +: 2]),
            .sat_o (lane_sat[g])
        );
    end

    always_comb ovf_evt = accept && is_arith && (|lane_sat);

    // State register of the result machine
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (accept)  state_d = RS_DONE;
            RS_DONE: if (!accept) state_d = RS_IDLE;
        endcase
    end

    // Output registers of the result machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            bad_q <= 1'b0;
        end else if (accept) begin
            res_q <= is_bad ? '0 : lane_res;
            bad_q <= is_bad;
        end else begin
            bad_q <= 1'b0;
        end
    end

    always_comb begin
        res_o       = res_q;
        res_valid_o = (state_q == RS_DONE);
        illegal_o   = bad_q;
    end

    tern_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ovf_evt),
        .clr_i  (ovf_clr_i),
        .flag_o (ovf_o)
    );

    for (genvar g = 0; g < NTRIT; g++) begin : g_canon
        a_r1_canon: assert property (@(posedge clk) disable iff (!rst_n)
            res_o[2*g +: 2] != 2'b10);
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(res_o) && !res_valid_o));
    a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> res_valid_o);
    a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (res_valid_o && (res_o == '0)));
    a_r10_ovf_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(accept && is_arith));

endmodule

// File: tb/tb_tern_alu.sv
module tb_tern_alu;

    localparam int N = 2;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         valid_i;
    logic [6:0]   opcode_i;
    logic [2:0]   funct3_i;
    logic [W-1:0] opa_i, opb_i;
    logic         ovf_clr_i;
    logic [W-1:0] res_o;
    logic         res_valid_o, ovf_o, illegal_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    tern_alu #(.NTRIT(N)) dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
        .funct3_i(funct3_i), .opa_i(opa_i), .opb_i(opb_i), .ovf_clr_i(ovf_clr_i),
        .res_o(res_o), .res_valid_o(res_valid_o), .ovf_o(ovf_o), .illegal_o(illegal_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dv(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    function automatic logic [1:0] ev(input int v);
        if (v > 0) return 2'b01;
        if (v < 0) return 2'b11;
        return 2'b00;
    endfunction

    function automatic int mn(input int x, input int y); return (x < y) ? x : y; endfunction
    function automatic int mx(input int x, input int y); return (x > y) ? x : y; endfunction

    // Expected result and overflow for one operation
    task automatic model(input int f, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] r, output bit ov);
        r  = '0;
        ov = 1'b0;
        for (int i = 0; i < N; i++) begin
            int x = dv(a[2*i +: 2]);
            int y = dv(b[2*i +: 2]);
            int v = 0;
            case (f)
                0, 1: begin
                    v = x + ((f == 1) ? -y : y);
                    if (v > 1)  begin v = 1;  ov = 1'b1; end
                    if (v < -1) begin v = -1; ov = 1'b1; end
                end
                2: v = x * y;
                3: v = mn(x, y);
                4: v = mx(x, y);
                5: v = mx(mn(x, -y), mn(-x, y));
                6: v = -x;
                default: v = 0;
            endcase
            r[2*i +: 2] = ev(v);
        end
    endtask

    task automatic drive(input bit v, input logic [6:0] opc, input int f,
                         input logic [W-1:0] a, input logic [W-1:0] b, input bit clr);
        valid_i   = v;
        opcode_i  = opc;
        funct3_i  = 3'(f);
        opa_i     = a;
        opb_i     = b;
        ovf_clr_i = clr;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] er;
        logic [W-1:0] held;
        bit eo;
        string tag;

        rst_n = 1'b0;
        valid_i = 1'b1; opcode_i = 7'h0B; funct3_i = 3'd0;
        opa_i = 4'b0101; opb_i = 4'b0101; ovf_clr_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 res", int'(res_o), 0);
        chk("R12 valid", int'(res_valid_o), 0);
        chk("R12 ovf", int'(ovf_o), 0);
        chk("R12 illegal", int'(illegal_o), 0);
        rst_n = 1'b1;

        // Exhaustive sweep, clearing the flag with each op so the flag shows that op only
        for (int f = 0; f < 8; f++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    model(f, 4'(a), 4'(b), er, eo);
                    drive(1'b1, 7'h0B, f, 4'(a), 4'(b), 1'b1);
                    case (f)
                        0: tag = "R3 add";
                        1: tag = "R4 sub";
                        2: tag = "R5 mul";
                        3, 4: tag = "R6 min/max";
                        5: tag = "R7 xor";
                        6: tag = "R8 not";
                        default: tag = "R9 unused code";
                    endcase
                    chk(tag, int'(res_o), int'(er));
                    chk("R1 R2 valid pulse", int'(res_valid_o), 1);
                    chk("R9 illegal", int'(illegal_o), (f == 7) ? 1 : 0);
                    chk("R10 R11 ovf", int'(ovf_o), int'(eo));
                end
            end
        end

        // R8: operand b has no effect on negation
        drive(1'b1, 7'h0B, 6, 4'b0111, 4'b0000, 1'b0);
        held = res_o;
        drive(1'b1, 7'h0B, 6, 4'b0111, 4'b1111, 1'b0);
        chk("R8 b ignored", int'(res_o), int'(held));

        // R2: valid low and wrong opcode are ignored
        drive(1'b1, 7'h0B, 2, 4'b0101, 4'b1101, 1'b0);
        held = res_o;
        drive(1'b0, 7'h0B, 0, 4'b0101, 4'b0101, 1'b0);
        chk("R2 valid low pulse", int'(res_valid_o), 0);
        chk("R2 valid low hold", int'(res_o), int'(held));
        chk("R2 valid low ovf", int'(ovf_o), 0);
        drive(1'b1, 7'h2B, 0, 4'b0101, 4'b0101, 1'b0);
        chk("R2 wrong opcode pulse", int'(res_valid_o), 0);
        chk("R2 wrong opcode hold", int'(res_o), int'(held));
        chk("R2 wrong opcode ovf", int'(ovf_o), 0);

        // R10 stickiness
        drive(1'b1, 7'h0B, 0, 4'b0001, 4'b0001, 1'b0);
        chk("R10 set by add", int'(ovf_o), 1);
        drive(1'b1, 7'h0B, 0, 4'b0001, 4'b0000, 1'b0);
        chk("R10 sticky after clean add", int'(ovf_o), 1);
        drive(1'b1, 7'h0B, 2, 4'b1111, 4'b1111, 1'b0);
        chk("R10 sticky after mul", int'(ovf_o), 1);
        drive(1'b0, 7'h0B, 0, 4'b0000, 4'b0000, 1'b0);
        chk("R10 sticky while idle", int'(ovf_o), 1);

        // R11 clear, and clear colliding with an overflowing op
        drive(1'b0, 7'h0B, 0, 4'b0000, 4'b0000, 1'b1);
        chk("R11 clear", int'(ovf_o), 0);
        drive(1'b1, 7'h0B, 1, 4'b1100, 4'b0100, 1'b0);
        chk("R10 set by sub", int'(ovf_o), 1);
        drive(1'b1, 7'h0B, 1, 4'b1100, 4'b0100, 1'b1);
        chk("R11 set wins over clear", int'(ovf_o), 1);
        drive(1'b1, 7'h2B, 0, 4'b0101, 4'b0101, 1'b1);
        chk("R11 clear with ignored op", int'(ovf_o), 0);
        drive(1'b1, 7'h0B, 2, 4'b0101, 4'b0101, 1'b0);
        chk("R10 mul never sets", int'(ovf_o), 0);

        // R12: reset mid-run
        rst_n = 1'b0;
        drive(1'b1, 7'h0B, 7, 4'b0101, 4'b0101, 1'b0);
        chk("R12 reset res", int'(res_o), 0);
        chk("R12 reset valid", int'(res_valid_o), 0);
        chk("R12 reset illegal", int'(illegal_o), 0);
        rst_n = 1'b1;
        valid_i = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule